// File: doc/BRIEF.md
# Shift-Register Digital PWM Controller

This block produces the fixed-frequency switch command for a buck power stage. It runs from a single fast clock. A free-running counter divides that clock into a switching period of 64 phases and into a much slower step interval of 1024 cycles. Both slow rates are produced as one-cycle enable strobes inside the block, and as square-wave outputs for the rest of the converter.

The duty setting is a thermometer code with 63 legal states, from one set bit to all 63 set. The comparator result (converter output below or above its reference) is sampled once per switching period. At each step-interval boundary the code moves one state up or down, in the direction of the latest sample, and it saturates at both ends. Adjacent code bits are combined by XOR into a one-hot tap select. The PWM output is set at the start of every period and is cleared when the phase counter reaches the selected tap. The high time is therefore 1 to 63 fast-clock cycles out of 64.

Top module: `pwm_ctrl`

## Requirements
- R1: The PWM output is high in phase 0 of every 64-cycle switching period, where phase 0 is the cycle after the period strobe.
- R2: `clk_period` is a square wave at 1/64 of the system clock, high for 32 cycles of every period. `clk_shift` falls once every 1024 cycles.
- R3: The duty code changes only at the cycle in which `clk_shift` falls, and then by exactly one state. Comparator value 1 (output below reference) steps it up and value 0 steps it down.
- R4: At the top state (63 ones), an upward step leaves the code unchanged.
- R5: At the bottom state (one set bit), a downward step leaves the code unchanged.
- R6: After the synchronous active-low reset, the duty code holds its midpoint of 32 ones in bits 31..0 and the PWM output is low.
- R7: `duty_therm` always has the form 2^k-1 with k between 1 and 63, and `duty_count` equals k.
- R8: Within each switching period the PWM output is high for exactly `duty_count` consecutive cycles, starting at phase 0.
- R9: The step direction is the comparator value sampled at the last period boundary before the step. Changes of the comparator earlier in the step interval, and reversed afterwards, have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_below | input | 1 | Comparator decision: 1 = output below reference |
| pwm_out | output | 1 | Switch command to the power stage |
| duty_therm | output | 63 | Thermometer duty code, bit 0 is the lowest |
| duty_count | output | 6 | Number of set bits in the duty code |
| clk_period | output | 1 | Square wave at the switching rate |
| clk_shift | output | 1 | Square wave at the duty step rate |

## Verification
The comparator is first held high until the code climbs to the top and stays pinned there for several step intervals. It is then held low for a long descent to the bottom state, and finally raised again. This separates correct stepping from saturation at each end, and from a wrap or an overflow past either limit. In every step interval the pulse width of the following period is measured and compared with the expected code. This shows that the one-hot tap and the phase decode agree over all 63 widths. In some intervals the comparator is reversed for a stretch in the middle of the interval and restored before the last period boundary. A design that samples at the wrong instant then steps the wrong way.

// File: rtl/pwm_ctrl_pkg.sv
// Package: shared types of the PWM controller.
// Assumes: nothing beyond IEEE 1800-2017.
package pwm_ctrl_pkg;
    // Direction of one duty step, taken from the sampled comparator.
    typedef enum logic [0:0] {
        STEP_DOWN = 1'b0,
        STEP_UP   = 1'b1
    } step_dir_e;
endpackage

// File: rtl/pwm_rate_gen.sv
// Module: free-running divider that makes the phase index, the period and
// step strobes, and square-wave versions of both slow rates.
// Assumes: DIV_BITS > PHASE_BITS, with both rates powers of two of clk.
module pwm_rate_gen #(
    parameter int PHASE_BITS = 6,
    parameter int DIV_BITS   = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [PHASE_BITS-1:0] phase,
    output logic                  period_end,
    output logic                  shift_end,
    output logic                  clk_period,
    output logic                  clk_shift
);
    logic [DIV_BITS-1:0] div_q;

    // Advance the divider on every fast-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign phase      = div_q[PHASE_BITS-1:0];
    assign period_end = &div_q[PHASE_BITS-1:0];
    assign shift_end  = &div_q;
    assign clk_period = div_q[PHASE_BITS-1];
    assign clk_shift  = div_q[DIV_BITS-1];
endmodule

// File: rtl/pwm_duty_reg.sv
// Module: bidirectional thermometer duty register with saturation, plus
// the comparator sample flop and a population count of the code.
// Assumes: WIDTH >= 2 and 1 <= RESET_ONES <= WIDTH; CW holds WIDTH.
module pwm_duty_reg
    import pwm_ctrl_pkg::*;
#(
    parameter int WIDTH      = 63,
    parameter int RESET_ONES = 32,
    parameter int CW         = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             shift_en,
    input  logic             cmp_below,
    output logic [WIDTH-1:0] therm,
    output logic [CW-1:0]    count
);
    localparam logic [WIDTH-1:0] RST_CODE =
        {{(WIDTH-RESET_ONES){1'b0}}, {RESET_ONES{1'b1}}};

    step_dir_e        dir_q;
    logic [WIDTH-1:0] therm_q;
    logic             at_top;
    logic             at_bottom;
    logic [CW-1:0]    count_c;

    // Capture the comparator decision once per switching period.
    always_ff @(posedge clk) begin
        if (!rst_n)         dir_q <= STEP_DOWN;
        else if (sample_en) dir_q <= cmp_below ? STEP_UP : STEP_DOWN;
    end

    assign at_top    = therm_q[WIDTH-1];
    assign at_bottom = !therm_q[1];

    // Move the code one state on the step strobe, holding at either end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            therm_q <= RST_CODE;
        end else if (shift_en) begin
            if (dir_q == STEP_UP && !at_top)
                therm_q <= {therm_q[WIDTH-2:0], 1'b1};
            else if (dir_q == STEP_DOWN && !at_bottom)
                therm_q <= {1'b0, therm_q[WIDTH-1:1]};
        end
    end

    // Count the set bits of the code.
    always_comb begin
        count_c = '0;
        for (int i = 0; i < WIDTH; i++)
            count_c = count_c + CW'(therm_q[i]);
    end

    assign therm = therm_q;
    assign count = count_c;
endmodule

// File: rtl/pwm_tap_out.sv
// Module: turns the thermometer code into a one-hot tap select, matches it
// against the phase index and drives the registered PWM output.
// Assumes: the code is a valid thermometer with at least one set bit and
// changes only on the cycle of period_end.
module pwm_tap_out #(
    parameter int PHASE_BITS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PHASE_BITS-1:0] phase,
    input  logic                  period_end,
    input  logic [NTAP-1:0]       therm,
    output logic                  pwm
);
    localparam int NPH  = 1 << PHASE_BITS;
    localparam int NTAP = NPH - 1;

    logic [NTAP-1:0] sel;
    logic [NTAP-1:0] tap_hit;
    logic            clear_now;
    logic            pwm_q;

    // One-hot select from neighbouring code bits, and the phase decode.
    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        if (i == NTAP - 1) begin : g_last
            assign sel[i] = therm[i];
        end else begin : g_mid
            assign sel[i] = therm[i] ^ therm[i+1];
        end
        assign tap_hit[i] = (phase == PHASE_BITS'(i));
    end

    assign clear_now = |(sel & tap_hit);

    // Set at the period boundary, clear when the chosen tap fires.
    always_ff @(posedge clk) begin
        if (!rst_n)          pwm_q <= 1'b0;
        else if (period_end) pwm_q <= 1'b1;
        else if (clear_now)  pwm_q <= 1'b0;
    end

    assign pwm = pwm_q;
endmodule

// File: rtl/pwm_ctrl.sv
// Module: top of the digital PWM controller; divider, duty register and
// tap/output stage, all on one clock edge with internal enables.
// Assumes: PHASE_BITS < DIV_BITS; comparator input already synchronous.
module pwm_ctrl #(
    parameter int PHASE_BITS = 6,
    parameter int DIV_BITS   = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmp_below,
    output logic                      pwm_out,
    output logic [(1<<PHASE_BITS)-2:0] duty_therm,
    output logic [PHASE_BITS-1:0]     duty_count,
    output logic                      clk_period,
    output logic                      clk_shift
);
    localparam int NPH = 1 << PHASE_BITS;
    localparam int TW  = NPH - 1;
    localparam int MID = NPH / 2;

    logic [PHASE_BITS-1:0] phase;
    logic                  period_end;
    logic                  shift_end;
    logic [TW-1:0]         therm;

    pwm_rate_gen #(.PHASE_BITS(PHASE_BITS), .DIV_BITS(DIV_BITS)) i_rate (
        .clk(clk), .rst_n(rst_n), .phase(phase), .period_end(period_end),
        .shift_end(shift_end), .clk_period(clk_period), .clk_shift(clk_shift)
    );

    pwm_duty_reg #(.WIDTH(TW), .RESET_ONES(MID), .CW(PHASE_BITS)) i_duty (
        .clk(clk), .rst_n(rst_n), .sample_en(period_end), .shift_en(shift_end),
        .cmp_below(cmp_below), .therm(therm), .count(duty_count)
    );

    pwm_tap_out #(.PHASE_BITS(PHASE_BITS)) i_tap (
        .clk(clk), .rst_n(rst_n), .phase(phase), .period_end(period_end),
        .therm(therm), .pwm(pwm_out)
    );

    assign duty_therm = therm;
endmodule

// File: rtl/pwm_ctrl_chk.sv
// Module: property checker bound to pwm_ctrl; watches only its ports.
// Assumes: reset is asserted from time zero for at least one clock.
module pwm_ctrl_chk #(
    parameter int PHASE_BITS = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       pwm_out,
    input logic [(1<<PHASE_BITS)-2:0] duty_therm,
    input logic [PHASE_BITS-1:0]      duty_count,
    input logic                       clk_period,
    input logic                       clk_shift
);
    logic [PHASE_BITS:0] hi_run;

    // Length of the current high run of the PWM output.
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_run <= '0;
        else if (pwm_out) hi_run <= hi_run + 1'b1;
        else              hi_run <= '0;
    end

    AST_PERIOD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_period) |-> pwm_out); // R1

    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(clk_shift) |-> $stable(duty_therm)); // R3

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(duty_therm ^ $past(duty_therm)) <= 1); // R3

    AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        duty_therm[0] && ((duty_therm & (duty_therm + 1'b1)) == '0)); // R7

    AST_PWM_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_out) |-> (hi_run == {1'b0, duty_count})); // R8
endmodule

bind pwm_ctrl pwm_ctrl_chk #(.PHASE_BITS(PHASE_BITS)) i_chk (
    .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .duty_therm(duty_therm),
    .duty_count(duty_count), .clk_period(clk_period), .clk_shift(clk_shift)
);

// File: tb/test_pwm_ctrl.sv
// Bench: scoreboard. The driver sets the comparator per step interval and
// queues the expected duty; the monitor pops and checks code and width.
module test_pwm_ctrl;
    localparam int PB  = 6;
    localparam int DB  = 10;
    localparam int TW  = (1 << PB) - 1;
    localparam int NUP = 35;
    localparam int NDN = 66;
    localparam int NRE = 4;
    localparam int NW  = NUP + NDN + NRE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp_below = 1'b1;
    logic          pwm_out;
    logic [TW-1:0] duty_therm;
    logic [PB-1:0] duty_count;
    logic          clk_period;
    logic          clk_shift;

    int total = 0;
    int bad = 0;
    int exp_q[$];
    event shift_ev;
    logic shift_prev = 1'b0;
    bit   seen_fall = 1'b0;
    int   gap = 0;

    pwm_ctrl #(.PHASE_BITS(PB), .DIV_BITS(DB)) i_pwm_ctrl (
        .clk(clk), .rst_n(rst_n), .cmp_below(cmp_below), .pwm_out(pwm_out),
        .duty_therm(duty_therm), .duty_count(duty_count),
        .clk_period(clk_period), .clk_shift(clk_shift)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [TW-1:0] mask_of(input int k);
        logic [63:0] m;
        m = (64'd1 << k) - 64'd1;
        return m[TW-1:0];
    endfunction

    // Detect falls of the step clock and check their spacing (R2).
    always @(negedge clk) begin
        if (rst_n) begin
            gap++;
            if (shift_prev && !clk_shift) begin
                if (seen_fall) check(gap == 1024, "R2 shift spacing", gap, 1024);
                seen_fall = 1'b1;
                gap = 0;
                ->shift_ev;
            end
            shift_prev = clk_shift;
        end
    end

    // Give up on a hung run.
    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic driver();
        int e;
        bit d;
        e = 33;
        for (int i = 0; i < NW; i++) begin
            @(shift_ev);
            d = (i < NUP) ? 1'b1 : (i < NUP + NDN) ? 1'b0 : 1'b1;
            cmp_below = d;
            e = d ? ((e < TW) ? e + 1 : e) : ((e > 1) ? e - 1 : e);
            exp_q.push_back(e);
            if (i % 3 == 0) begin
                // R9: reverse the comparator mid-interval, restore before the last sample
                repeat (200) @(negedge clk);
                cmp_below = ~d;
                repeat (300) @(negedge clk);
                cmp_below = d;
            end
        end
    endtask

    task automatic monitor();
        int e;
        int hi;
        int cp;
        bit first;
        string tag;
        @(shift_ev);
        #1;
        check(duty_count == 33, "R3 first step up", duty_count, 33);
        for (int i = 0; i < NW; i++) begin
            @(shift_ev);
            #1;
            e = exp_q.pop_front();
            tag = (e == TW) ? "R4 top hold" : (e == 1) ? "R5 bottom hold" : "R3 step";
            check(duty_count == PB'(e), tag, duty_count, e);
            check(duty_therm == mask_of(e), "R7 code shape", duty_count, e);
            check(!$isunknown(cmp_below), "R9 sample", duty_count, e);
            hi = 0;
            cp = 0;
            first = pwm_out;
            for (int j = 0; j < 64; j++) begin
                if (j > 0) @(negedge clk);
                hi += int'(pwm_out);
                cp += int'(clk_period);
            end
            check(first == 1'b1, "R1 period start", first, 1);
            check(hi == e, "R8 pulse width", hi, e);
            check(cp == 32, "R2 period clock", cp, 32);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(duty_count == 32, "R6 reset count", duty_count, 32);
        check(duty_therm == mask_of(32), "R6 reset code", duty_count, 32);
        check(pwm_out == 1'b0, "R6 reset pwm", pwm_out, 0);
        rst_n = 1'b1;
        repeat (600) @(negedge clk);
        check(duty_count == 32, "R3 hold before step", duty_count, 32);
        fork
            driver();
            monitor();
        join
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule